// File: doc/BRIEF.md
# Frame-Latched 2-D FIR Kernel

This block turns a K-by-K window of unsigned pixels, delivered in parallel each cycle by an upstream neighbourhood generator, into a single filtered output pixel. Every window element is multiplied by its own signed 16-bit fixed-point weight. The products go through a registered adder tree, and the sum is brought back to the input pixel width. The shift that drops the fractional bits uses either floor or round-to-nearest. An out-of-range result is either clamped or wrapped. Both choices are made by quasi-static mode inputs.

The weight matrix arrives on a wide parallel input. The block takes it only on the first valid pixel of a frame, so a host may rewrite the weights at any time without tearing the current image. The five framing flags travel through a delay line of the same length as the arithmetic, so they leave the block beside the pixel they describe. The kernel dimension K is an elaboration parameter, and any value outside 2 to 64 stops elaboration. Line storage, edge padding and multi-pixel vectors belong to neighbouring blocks.

Top module: `fir2d_kernel`

## Requirements
- R1: While reset is held and after it is released, `valid_o`, all four position flags and `pix_o` stay 0 until the first valid input has crossed the pipeline.
- R2: Window element i, where i = row*K + col, sits at `win_i[i*PIX_W +: PIX_W]` as an unsigned value. Its weight is the two's-complement value at `coef_i[i*COEF_W +: COEF_W]`, and FRAC_W of the weight's bits are fractional. The result is the sum of the K*K products shifted right by FRAC_W. In the default mode that shift is a floor.
- R3: Each valid input produces exactly one valid output, LAT = 5 + clog2(K*K) cycles later (9 for K=3). Back-to-back valid inputs give back-to-back outputs.
- R4: `hstart_o`, `hend_o`, `vstart_o` and `vend_o` are the corresponding inputs delayed by the same LAT cycles.
- R5: The weights are captured on a cycle where `valid_i`, `vstart_i` and `hstart_i` are all 1. The pixel of that same cycle is already filtered with the new weights.
- R6: On every other cycle, including a line start without `vstart_i`, values on `coef_i` have no effect on results.
- R7: With `round_nearest_i`=1, half an output LSB is added before the shift, so ties round upward.
- R8: With `saturate_i`=1, a negative result gives 0 and a result above 2^PIX_W-1 gives 2^PIX_W-1.
- R9: With `saturate_i`=0, the output is the low PIX_W bits of the shifted result (modulo wrap).
- R10: `pix_o` is 0 on every cycle where `valid_o` is 0.
- R11: Reset clears the latched weights, so a valid pixel sent before any frame start yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_i | input | K*K*PIX_W | Pixel window, element i at bits i*PIX_W |
| coef_i | input | K*K*COEF_W | Candidate weights, element i at bits i*COEF_W |
| valid_i | input | 1 | Window is valid |
| hstart_i | input | 1 | First pixel of a line |
| hend_i | input | 1 | Last pixel of a line |
| vstart_i | input | 1 | First line of a frame |
| vend_i | input | 1 | Last line of a frame |
| round_nearest_i | input | 1 | 1: round to nearest, 0: floor |
| saturate_i | input | 1 | 1: clamp, 0: wrap |
| pix_o | output | PIX_W | Filtered pixel |
| valid_o | output | 1 | Output pixel is valid |
| hstart_o | output | 1 | Delayed line-start flag |
| hend_o | output | 1 | Delayed line-end flag |
| vstart_o | output | 1 | Delayed frame-start flag |
| vend_o | output | 1 | Delayed frame-end flag |

## Verification
Every result is due exactly LAT = 9 clock edges after the edge that sampled its input. This covers two operand registers, two product registers, four tree levels and one cast register. The driver stamps each expected pixel and flag set with the cycle count at which it was applied. The monitor samples on the falling edge and requires the difference between the current count and that stamp to equal LAT. The rounding and overflow modes act on the final register, so the bench drains the pipeline for more than LAT idle cycles before it changes either mode.

// File: rtl/fir2d_pkg.sv
package fir2d_pkg;
  typedef struct packed {
    logic valid;
    logic hstart;
    logic hend;
    logic vstart;
    logic vend;
  } ctrl_t;
endpackage

// File: rtl/fir2d_coef_latch.sv
module fir2d_coef_latch #(
  parameter int TAPS   = 9,
  parameter int COEF_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [TAPS*COEF_W-1:0] coef_i,
  output logic [TAPS*COEF_W-1:0] bank_o,
  output logic [TAPS*COEF_W-1:0] use_o
);
  logic [TAPS*COEF_W-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bank_q <= '0;
    else if (load_i) bank_q <= coef_i;
  end

  // frame-start pixel already uses the incoming set
  assign use_o  = load_i ? coef_i : bank_q;
  assign bank_o = bank_q;
endmodule

// File: rtl/fir2d_mul_lane.sv
module fir2d_mul_lane #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [PIX_W-1:0]          pix_i,
  input  logic [COEF_W-1:0]         coef_i,
  output logic [PIX_W+COEF_W:0]     prod_o
);
  localparam int PROD_W = PIX_W + COEF_W + 1;

  logic [PIX_W-1:0]         a1_q, a2_q;
  logic [COEF_W-1:0]        b1_q, b2_q;
  logic signed [PROD_W-1:0] ax, bx, p1_q, p2_q;

  assign ax = {{(PROD_W-PIX_W){1'b0}}, a2_q};
  assign bx = {{(PROD_W-COEF_W){b2_q[COEF_W-1]}}, b2_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a1_q <= '0; a2_q <= '0;
      b1_q <= '0; b2_q <= '0;
      p1_q <= '0; p2_q <= '0;
    end else begin
      a1_q <= pix_i;  a2_q <= a1_q;
      b1_q <= coef_i; b2_q <= b1_q;
      p1_q <= ax * bx;
      p2_q <= p1_q;
    end
  end

  assign prod_o = p2_q;
endmodule

// File: rtl/fir2d_add_tree.sv
module fir2d_add_tree #(
  parameter int N_IN = 9,
  parameter int IN_W = 25,
  parameter int OUT_W = IN_W + $clog2(N_IN)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_IN*IN_W-1:0]    in_i,
  output logic signed [OUT_W-1:0] sum_o
);
  localparam int LVL = $clog2(N_IN);
  localparam int NP  = 1 << LVL;

  logic signed [OUT_W-1:0] leaf   [NP];
  logic signed [OUT_W-1:0] node_q [NP-1];

  for (genvar i = 0; i < NP; i++) begin : g_leaf
    if (i < N_IN) begin : g_real
      logic [IN_W-1:0] s;
      assign s       = in_i[i*IN_W +: IN_W];
      assign leaf[i] = {{(OUT_W-IN_W){s[IN_W-1]}}, s};
    end else begin : g_pad
      assign leaf[i] = '0;
    end
  end

  // heap order: node n has children 2n+1, 2n+2; leaves follow the NP-1 nodes
  for (genvar n = 0; n < NP-1; n++) begin : g_node
    localparam int LC = 2*n + 1;
    logic signed [OUT_W-1:0] lv, rv;
    if (LC >= NP-1) begin : g_from_leaf
      assign lv = leaf[LC-(NP-1)];
      assign rv = leaf[LC+1-(NP-1)];
    end else begin : g_from_node
      assign lv = node_q[LC];
      assign rv = node_q[LC+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) node_q[n] <= '0;
      else         node_q[n] <= lv + rv;
    end
  end

  assign sum_o = node_q[0];
endmodule

// File: rtl/fir2d_out_cast.sv
module fir2d_out_cast #(
  parameter int ACC_W  = 29,
  parameter int FRAC_W = 4,
  parameter int PIX_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ACC_W-1:0] sum_i,
  input  logic                    round_nearest_i,
  input  logic                    saturate_i,
  output logic [PIX_W-1:0]        pix_o
);
  localparam logic signed [ACC_W:0] HALF    = (ACC_W+1)'((1 << FRAC_W) >> 1);
  localparam logic signed [ACC_W:0] PIX_MAX = (ACC_W+1)'((1 << PIX_W) - 1);

  logic signed [ACC_W:0] ext, rnd, shf;
  logic [PIX_W-1:0]      cast;

  assign ext = {sum_i[ACC_W-1], sum_i};
  assign rnd = ext + (round_nearest_i ? HALF : '0);
  assign shf = rnd >>> FRAC_W;

  always_comb begin
    cast = shf[PIX_W-1:0];
    if (saturate_i) begin
      if (shf < 0)            cast = '0;
      else if (shf > PIX_MAX) cast = '1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_o <= '0;
    else         pix_o <= cast;
  end
endmodule

// File: rtl/fir2d_kernel.sv
module fir2d_kernel #(
  parameter int K      = 3,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [K*K*PIX_W-1:0]     win_i,
  input  logic [K*K*COEF_W-1:0]    coef_i,
  input  logic                     valid_i,
  input  logic                     hstart_i,
  input  logic                     hend_i,
  input  logic                     vstart_i,
  input  logic                     vend_i,
  input  logic                     round_nearest_i,
  input  logic                     saturate_i,
  output logic [PIX_W-1:0]         pix_o,
  output logic                     valid_o,
  output logic                     hstart_o,
  output logic                     hend_o,
  output logic                     vstart_o,
  output logic                     vend_o
);
  import fir2d_pkg::*;

  localparam int TAPS   = K * K;
  localparam int PROD_W = PIX_W + COEF_W + 1;
  localparam int LVL    = $clog2(TAPS);
  localparam int ACC_W  = PROD_W + LVL;
  localparam int LAT    = 4 + LVL + 1;

  if (K < 2 || K > 64) begin : g_bad_k
    $error("fir2d_kernel: K must lie in 2..64");
  end

  logic                     frame_start;
  logic [TAPS*COEF_W-1:0]   coef_bank, coef_use;
  logic [TAPS*PROD_W-1:0]   prods;
  logic signed [ACC_W-1:0]  acc;
  logic [PIX_W-1:0]         pix_q;
  ctrl_t                    ctrl_in;
  ctrl_t                    ctrl_pipe [LAT];

  assign frame_start = valid_i & vstart_i & hstart_i;

  fir2d_coef_latch #(.TAPS(TAPS), .COEF_W(COEF_W)) u_coef (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (frame_start),
    .coef_i (coef_i),
    .bank_o (coef_bank),
    .use_o  (coef_use)
  );

  for (genvar i = 0; i < TAPS; i++) begin : g_lane
    fir2d_mul_lane #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_mul (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pix_i  (win_i[i*PIX_W +: PIX_W]),
      .coef_i (coef_use[i*COEF_W +: COEF_W]),
      .prod_o (prods[i*PROD_W +: PROD_W])
    );
  end

  fir2d_add_tree #(.N_IN(TAPS), .IN_W(PROD_W), .OUT_W(ACC_W)) u_tree (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (prods),
    .sum_o  (acc)
  );

  fir2d_out_cast #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .PIX_W(PIX_W)) u_cast (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sum_i           (acc),
    .round_nearest_i (round_nearest_i),
    .saturate_i      (saturate_i),
    .pix_o           (pix_q)
  );

  assign ctrl_in = '{valid: valid_i, hstart: hstart_i, hend: hend_i,
                     vstart: vstart_i, vend: vend_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LAT; i++) ctrl_pipe[i] <= '0;
    end else begin
      ctrl_pipe[0] <= ctrl_in;
      for (int i = 1; i < LAT; i++) ctrl_pipe[i] <= ctrl_pipe[i-1];
    end
  end

  assign valid_o  = ctrl_pipe[LAT-1].valid;
  assign hstart_o = ctrl_pipe[LAT-1].hstart;
  assign hend_o   = ctrl_pipe[LAT-1].hend;
  assign vstart_o = ctrl_pipe[LAT-1].vstart;
  assign vend_o   = ctrl_pipe[LAT-1].vend;
  assign pix_o    = valid_o ? pix_q : '0;
endmodule

// File: rtl/fir2d_kernel_chk.sv
module fir2d_kernel_chk #(
  parameter int K      = 3,
  parameter int COEF_W = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic                  hstart_i,
  input logic                  vstart_i,
  input logic [K*K*COEF_W-1:0] coef_i,
  input logic [K*K*COEF_W-1:0] coef_bank,
  input logic                  valid_o,
  input logic                  hstart_o,
  input logic                  vstart_o
);
  localparam int LAT = 5 + $clog2(K*K);

  logic [7:0] cnt_q;
  logic       warm, fstart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (cnt_q < 8'(LAT))    cnt_q <= cnt_q + 8'd1;
  end

  assign warm   = (cnt_q >= 8'(LAT));
  assign fstart = valid_i & vstart_i & hstart_i;

  p_quiet_after_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !warm |-> !valid_o);

  p_valid_delay_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (valid_o == $past(valid_i, LAT)));

  p_start_delay_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> ((vstart_o & hstart_o) == $past(vstart_i & hstart_i, LAT)));

  p_coef_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fstart |=> (coef_bank == $past(coef_i)));

  p_coef_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fstart |=> $stable(coef_bank));
endmodule

bind fir2d_kernel fir2d_kernel_chk #(.K(K), .COEF_W(COEF_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .hstart_i  (hstart_i),
  .vstart_i  (vstart_i),
  .coef_i    (coef_i),
  .coef_bank (coef_bank),
  .valid_o   (valid_o),
  .hstart_o  (hstart_o),
  .vstart_o  (vstart_o)
);

// File: tb/fir2d_kernel_test.sv
module fir2d_kernel_test;
  localparam int K      = 3;
  localparam int PIX_W  = 8;
  localparam int COEF_W = 16;
  localparam int FRAC_W = 4;
  localparam int TAPS   = K * K;
  localparam int LAT    = 5 + $clog2(TAPS);

  logic                   clk = 1'b0;
  logic                   rst_ni = 1'b0;
  logic [TAPS*PIX_W-1:0]  win_i = '0;
  logic [TAPS*COEF_W-1:0] coef_i = '0;
  logic valid_i = 0, hstart_i = 0, hend_i = 0, vstart_i = 0, vend_i = 0;
  logic round_nearest_i = 0, saturate_i = 0;
  logic [PIX_W-1:0] pix_o;
  logic valid_o, hstart_o, hend_o, vstart_o, vend_o;

  fir2d_kernel #(.K(K), .PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .win_i(win_i), .coef_i(coef_i),
    .valid_i(valid_i), .hstart_i(hstart_i), .hend_i(hend_i),
    .vstart_i(vstart_i), .vend_i(vend_i),
    .round_nearest_i(round_nearest_i), .saturate_i(saturate_i),
    .pix_o(pix_o), .valid_o(valid_o), .hstart_o(hstart_o), .hend_o(hend_o),
    .vstart_o(vstart_o), .vend_o(vend_o)
  );

  always #5 clk = ~clk;

  typedef struct {
    int     pix;
    bit     hs, he, vs, ve;
    longint cyc;
    string  tag;
  } exp_t;

  exp_t   sb[$];
  int     total = 0, bad = 0;
  longint cyc = 0;
  bit     done = 0;
  int     pv[TAPS], cv[TAPS], bank[TAPS];
  bit     rnd_m = 0, sat_m = 1;
  int     seed = 7;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lcg();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 32767;
  endfunction

  function automatic int model();
    longint s;
    s = 0;
    for (int i = 0; i < TAPS; i++) s += longint'(pv[i]) * longint'(bank[i]);
    if (rnd_m) s += longint'((1 << FRAC_W) >> 1);
    s = s >>> FRAC_W;
    if (sat_m) begin
      if (s < 0) s = 0;
      else if (s > (1 << PIX_W) - 1) s = (1 << PIX_W) - 1;
    end else begin
      s = s & ((1 << PIX_W) - 1);
    end
    return int'(s);
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit hs, bit he, bit vs, bit ve, string tag);
    exp_t e;
    @(negedge clk);
    for (int i = 0; i < TAPS; i++) begin
      win_i[i*PIX_W +: PIX_W]    = PIX_W'(pv[i]);
      coef_i[i*COEF_W +: COEF_W] = COEF_W'(cv[i]);
    end
    valid_i = v; hstart_i = hs; hend_i = he; vstart_i = vs; vend_i = ve;
    round_nearest_i = rnd_m; saturate_i = sat_m;
    if (v && vs && hs) for (int i = 0; i < TAPS; i++) bank[i] = cv[i];
    if (v) begin
      e.pix = model(); e.hs = hs; e.he = he; e.vs = vs; e.ve = ve;
      e.cyc = cyc; e.tag = tag;
      sb.push_back(e);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, "idle");
  endtask

  task automatic fill_pix(int lo, int span);
    for (int i = 0; i < TAPS; i++) pv[i] = lo + (lcg() % span);
  endtask

  task automatic set_coef(int val);
    for (int i = 0; i < TAPS; i++) cv[i] = val;
  endtask

  task automatic rand_coef(int mag);
    for (int i = 0; i < TAPS; i++) cv[i] = (lcg() % (2*mag + 1)) - mag;
  endtask

  // scoreboard monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (valid_o) begin
        if (sb.size() == 0) begin
          check(0, "R3", "unexpected valid_o", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(pix_o == PIX_W'(e.pix), e.tag, "pix_o", pix_o, e.pix);
          check({hstart_o, hend_o, vstart_o, vend_o} == {e.hs, e.he, e.vs, e.ve},
                "R4", "flags", {hstart_o, hend_o, vstart_o, vend_o},
                {e.hs, e.he, e.vs, e.ve});
          check(cyc - e.cyc == LAT, "R3", "latency", cyc - e.cyc, LAT);
        end
      end else begin
        check(pix_o == '0, "R10", "pix_o while idle", pix_o, 0);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < TAPS; i++) begin pv[i] = 0; cv[i] = 0; bank[i] = 0; end
    repeat (3) @(negedge clk);
    check(valid_o == 0 && pix_o == 0, "R1", "outputs in reset", {valid_o, pix_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check({valid_o, hstart_o, hend_o, vstart_o, vend_o} == 0, "R1", "flags after reset",
          {valid_o, hstart_o, hend_o, vstart_o, vend_o}, 0);
    check(pix_o == 0, "R1", "pix after reset", pix_o, 0);

    // R11: cleared bank, coef_i nonzero but no frame start
    for (int i = 0; i < TAPS; i++) pv[i] = 200;
    set_coef(16);
    step(1, 0, 0, 0, 0, "R11");
    idle(3);

    // frame A: centre tap 1.0, pass-through
    set_coef(0); cv[TAPS/2] = 16;
    fill_pix(0, 256); step(1, 1, 0, 1, 0, "R5");
    for (int i = 0; i < 5; i++) begin fill_pix(0, 256); step(1, 0, 0, 0, 0, "R2"); end
    idle(2);
    fill_pix(0, 256); step(1, 0, 1, 0, 0, "R4");
    set_coef(-300);
    for (int i = 0; i < 4; i++) begin fill_pix(0, 256); step(1, 0, 0, 0, 0, "R6"); end
    fill_pix(0, 256); step(1, 0, 1, 0, 1, "R4");
    idle(4);

    // frame B: mixed-sign fractional weights, line start inside frame
    rand_coef(48);
    fill_pix(0, 256); step(1, 1, 0, 1, 0, "R5");
    for (int i = 0; i < 6; i++) begin fill_pix(0, 256); step(1, 0, 0, 0, 0, "R2"); end
    step(0, 0, 1, 0, 0, "idle");
    rand_coef(48);
    fill_pix(0, 256); step(1, 1, 0, 0, 0, "R6");
    for (int i = 0; i < 4; i++) begin fill_pix(0, 256); step(1, 0, 0, 0, 0, "R6"); end
    idle(LAT + 2);

    // saturation high and low
    set_coef(64);
    fill_pix(128, 128); step(1, 1, 0, 1, 0, "R8");
    for (int i = 0; i < 3; i++) begin fill_pix(128, 128); step(1, 0, 0, 0, 0, "R8"); end
    set_coef(-64);
    fill_pix(1, 255); step(1, 1, 0, 1, 0, "R8");
    for (int i = 0; i < 3; i++) begin fill_pix(1, 255); step(1, 0, 0, 0, 0, "R8"); end
    idle(LAT + 2);

    // wrap
    sat_m = 0;
    set_coef(64);
    fill_pix(128, 128); step(1, 1, 0, 1, 0, "R9");
    for (int i = 0; i < 3; i++) begin fill_pix(128, 128); step(1, 0, 0, 0, 0, "R9"); end
    set_coef(-64);
    fill_pix(1, 255); step(1, 1, 0, 1, 0, "R9");
    for (int i = 0; i < 3; i++) begin fill_pix(1, 255); step(1, 0, 0, 0, 0, "R9"); end
    idle(LAT + 2);

    // nearest rounding: exact tie 5*0.5 = 2.5 -> 3, then random fractions
    sat_m = 1; rnd_m = 1;
    set_coef(0); cv[TAPS/2] = 8;
    for (int i = 0; i < TAPS; i++) pv[i] = 5;
    step(1, 1, 0, 1, 0, "R7");
    pv[TAPS/2] = 7; step(1, 0, 0, 0, 0, "R7");
    rand_coef(20);
    fill_pix(0, 256); step(1, 1, 0, 1, 0, "R7");
    for (int i = 0; i < 8; i++) begin fill_pix(0, 256); step(1, 0, 0, 0, 0, "R7"); end
    idle(LAT + 2);

    // throughput: back-to-back run
    rnd_m = 0;
    rand_coef(30);
    fill_pix(0, 256); step(1, 1, 0, 1, 0, "R3");
    for (int i = 0; i < 20; i++) begin fill_pix(0, 256); step(1, 0, (i % 7) == 6, 0, i == 19, "R3"); end
    idle(LAT + 3);

    check(sb.size() == 0, "R3", "missing outputs", sb.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule